// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides whether the identifier of a received CAN frame belongs to one of fifteen message slots, and which slot takes it. The frame side presents an identifier, a flag that tells an 11-bit standard identifier from a 29-bit extended one, and a one-cycle strobe. One clock later the block reports a hit flag and the number of the winning slot.

Each slot holds a configured identifier, a direction (receive or transmit), an enable and a frame format. Slots 1 to 14 are compared through one shared global mask. Slot 15 accepts frames only and is compared through a second mask of its own, so a single slot can take a whole group of identifiers. A mask bit of 1 demands equality in that position and a mask bit of 0 makes the position a don't-care. A host programs the masks and slots through a single-cycle write port.

Top module: `can_accept_filter`

## Requirements
- R1: After reset `hit` is 0, `hit_idx` is 0, every slot is disabled and both masks are all ones.
- R2: `hit` and `hit_idx` are registered: a strobe on `rx_valid` sampled at clock edge k gives its result after edge k, and after any edge where `rx_valid` was 0 `hit` is 0; frames on consecutive cycles give consecutive results.
- R3: A standard frame compares only `rx_id[10:0]` (bits 28..11 are ignored); an extended frame compares all of `rx_id[28:0]`.
- R4: For slots 1 to 14, an identifier bit whose global mask bit is 0 is ignored and one whose mask bit is 1 must equal the slot's identifier bit.
- R5: A frame matches a slot only when `rx_ext` equals the slot's format bit (0 standard, 1 extended).
- R6: A slot whose direction bit is 1 (transmit) or whose enable bit is 0 never produces a hit.
- R7: When several slots match, the lowest slot number wins; slot 15 wins only if slots 1 to 14 all miss.
- R8: Slot 15 is compared through the last-slot mask, not the global mask, and always acts as a receive slot: the direction bit written to it is discarded.
- R9: A write with `cfg_we`=1 decodes `cfg_addr`: 0 loads the global mask from `cfg_id`, 1..15 loads that slot (`cfg_id`, `cfg_tx`, `cfg_en`, `cfg_ext`), 16 loads the last-slot mask, 17..31 change nothing. A frame strobed in the same cycle as a write is judged against the contents before the write.
- R10: On a miss `hit` is 0 and `hit_idx` is 0; on a hit `hit_idx` is the slot number 1..15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a frame identifier is present |
| rx_id | input | 29 | Received identifier; standard frames use bits 10..0 |
| rx_ext | input | 1 | 1 for extended frame, 0 for standard |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 5 | 0 global mask, 1..15 slot, 16 last-slot mask |
| cfg_id | input | 29 | Identifier or mask value to write |
| cfg_tx | input | 1 | Slot direction: 1 transmit, 0 receive |
| cfg_en | input | 1 | Slot enable |
| cfg_ext | input | 1 | Slot format: 1 extended, 0 standard |
| hit | output | 1 | Registered acceptance flag |
| hit_idx | output | 4 | Registered number of winning slot, 0 on miss |

## Verification
The two functions that can coincide are a configuration write and a frame strobe. The bench raises both in one cycle, disabling the very slot the frame would hit, and expects the old slot to win; the next frame, with no write beside it, must then fall through to slot 15. Consecutive strobes without gaps also check that the scoreboard sees one result per frame in order.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
    localparam int ID_W      = 29;
    localparam int STD_W     = 11;
    localparam int NUM_SLOTS = 15;
    localparam int IDX_W     = $clog2(NUM_SLOTS + 1);
    localparam int ADDR_W    = $clog2(NUM_SLOTS + 2);

    typedef struct packed {
        logic [ID_W-1:0] id;
        logic            tx;
        logic            en;
        logic            ext;
    } slot_t;
endpackage

// File: rtl/can_filt_cfg.sv
module can_filt_cfg
    import can_filt_pkg::*;
#(
    parameter int N   = NUM_SLOTS,
    parameter int IW  = ID_W,
    parameter int AW  = ADDR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [AW-1:0]       cfg_addr,
    input  logic [IW-1:0]       cfg_id,
    input  logic                cfg_tx,
    input  logic                cfg_en,
    input  logic                cfg_ext,
    output logic [IW-1:0]       gmask,
    output logic [IW-1:0]       lmask,
    output slot_t [N-1:0]       slots
);
    localparam logic [AW-1:0] ADDR_GMASK = '0;
    localparam logic [AW-1:0] ADDR_LMASK = AW'(N + 1);

    typedef struct packed {
        logic [IW-1:0] gmask;
        logic [IW-1:0] lmask;
        slot_t [N-1:0] slots;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            if (cfg_addr == ADDR_GMASK) begin
                st_d.gmask = cfg_id;
            end
            if (cfg_addr == ADDR_LMASK) begin
                st_d.lmask = cfg_id;
            end
            for (int i = 0; i < N; i++) begin
                if (cfg_addr == AW'(i + 1)) begin
                    st_d.slots[i].id  = cfg_id;
                    st_d.slots[i].tx  = (i == N - 1) ? 1'b0 : cfg_tx;
                    st_d.slots[i].en  = cfg_en;
                    st_d.slots[i].ext = cfg_ext;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.gmask <= '1;
            st_q.lmask <= '1;
            st_q.slots <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gmask = st_q.gmask;
    assign lmask = st_q.lmask;
    assign slots = st_q.slots;
endmodule

// File: rtl/can_filt_match.sv
module can_filt_match
    import can_filt_pkg::*;
#(
    parameter int N  = NUM_SLOTS,
    parameter int IW = ID_W,
    parameter int SW = STD_W
) (
    input  logic [IW-1:0]  rx_id,
    input  logic           rx_ext,
    input  logic [IW-1:0]  gmask,
    input  logic [IW-1:0]  lmask,
    input  slot_t [N-1:0]  slots,
    output logic [N-1:0]   match_vec
);
    localparam logic [IW-1:0] STD_FIELD = {{(IW-SW){1'b0}}, {SW{1'b1}}};

    logic [IW-1:0] width_mask;
    assign width_mask = rx_ext ? '1 : STD_FIELD;

    for (genvar g = 0; g < N; g++) begin : g_slot
        logic [IW-1:0] eff_mask;
        logic          id_eq;
        if (g == N - 1) begin : g_last
            assign eff_mask = lmask & width_mask;
        end else begin : g_shared
            assign eff_mask = gmask & width_mask;
        end
        assign id_eq = (((slots[g].id ^ rx_id) & eff_mask) == '0);
        assign match_vec[g] = slots[g].en & ~slots[g].tx
                            & (slots[g].ext == rx_ext) & id_eq;
    end
endmodule

// File: rtl/can_filt_prio.sv
module can_filt_prio #(
    parameter int N  = 15,
    parameter int XW = $clog2(N + 1)
) (
    input  logic [N-1:0]  match_vec,
    output logic          any,
    output logic [XW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                idx = XW'(i + 1);
            end
        end
        any = |match_vec;
    end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
    import can_filt_pkg::*;
#(
    parameter int N  = NUM_SLOTS,
    parameter int IW = ID_W,
    parameter int SW = STD_W,
    parameter int AW = ADDR_W,
    parameter int XW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [IW-1:0] rx_id,
    input  logic          rx_ext,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [IW-1:0] cfg_id,
    input  logic          cfg_tx,
    input  logic          cfg_en,
    input  logic          cfg_ext,
    output logic          hit,
    output logic [XW-1:0] hit_idx
);
    typedef struct packed {
        logic          hit;
        logic [XW-1:0] idx;
    } res_t;

    logic [IW-1:0] gmask, lmask;
    slot_t [N-1:0] slots;
    logic [N-1:0]  match_vec;
    logic          any_match;
    logic [XW-1:0] win_idx;
    res_t          res_d, res_q;

    can_filt_cfg #(.N(N), .IW(IW), .AW(AW)) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_id   (cfg_id),
        .cfg_tx   (cfg_tx),
        .cfg_en   (cfg_en),
        .cfg_ext  (cfg_ext),
        .gmask    (gmask),
        .lmask    (lmask),
        .slots    (slots)
    );

    can_filt_match #(.N(N), .IW(IW), .SW(SW)) match_i (
        .rx_id     (rx_id),
        .rx_ext    (rx_ext),
        .gmask     (gmask),
        .lmask     (lmask),
        .slots     (slots),
        .match_vec (match_vec)
    );

    can_filt_prio #(.N(N), .XW(XW)) prio_i (
        .match_vec (match_vec),
        .any       (any_match),
        .idx       (win_idx)
    );

    always_comb begin
        res_d.hit = rx_valid & any_match;
        res_d.idx = res_d.hit ? win_idx : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign hit     = res_q.hit;
    assign hit_idx = res_q.idx;
endmodule

// File: rtl/can_accept_filter_chk.sv
module can_accept_filter_chk #(
    parameter int N  = 15,
    parameter int XW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_valid,
    input logic          hit,
    input logic [XW-1:0] hit_idx,
    input logic [N-1:0]  match_vec
);
    p_hit_needs_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(rx_valid));

    p_idle_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> !hit);

    p_miss_idx_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> hit_idx == '0);

    p_hit_idx_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (hit_idx != '0) && (hit_idx <= XW'(N)));

    p_last_only_fallback_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && hit_idx == XW'(N)) |-> ($past(match_vec[N-2:0]) == '0));
endmodule

bind can_accept_filter can_accept_filter_chk #(.N(N), .XW(XW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .hit       (hit),
    .hit_idx   (hit_idx),
    .match_vec (match_vec)
);

// File: tb/can_accept_filter_tb_top.sv
`timescale 1ns/1ps
module can_accept_filter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [28:0] rx_id = '0;
    logic        rx_ext = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [28:0] cfg_id = '0;
    logic        cfg_tx = 1'b0;
    logic        cfg_en = 1'b0;
    logic        cfg_ext = 1'b0;
    logic        hit;
    logic [3:0]  hit_idx;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic seen = 1'b0;

    typedef struct {
        logic       hit;
        logic [3:0] idx;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    can_accept_filter dut_i (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_id(rx_id),
        .rx_ext(rx_ext), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_id(cfg_id), .cfg_tx(cfg_tx), .cfg_en(cfg_en),
        .cfg_ext(cfg_ext), .hit(hit), .hit_idx(hit_idx)
    );

    task automatic check(input string tag, input logic h, input logic [3:0] ix);
        checks++;
        if (hit !== h || hit_idx !== ix) begin
            fails++;
            $display("FAIL %s: got hit=%0b idx=%0d, expected hit=%0b idx=%0d",
                     tag, hit, hit_idx, h, ix);
        end
    endtask

    // Monitor: a strobe seen at an edge has its result checked at the next falling edge
    always @(posedge clk) seen <= rx_valid;
    always @(negedge clk) begin
        if (seen) begin
            if (sb_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R2: result with no expected item, hit=%0b idx=%0d, expected none",
                         hit, hit_idx);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, e.hit, e.idx);
            end
        end
    end

    task automatic set_cfg(input logic [4:0] a, input logic [28:0] d,
                           input logic tx, input logic en, input logic ext);
        cfg_we = 1'b1; cfg_addr = a; cfg_id = d;
        cfg_tx = tx; cfg_en = en; cfg_ext = ext;
    endtask

    task automatic wr(input logic [4:0] a, input logic [28:0] d,
                      input logic tx, input logic en, input logic ext);
        set_cfg(a, d, tx, en, ext);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic push_frame(input logic [28:0] id, input logic ext,
                              input logic h, input logic [3:0] ix, input string tag);
        exp_t e;
        e.hit = h; e.idx = h ? ix : 4'd0; e.tag = tag;
        sb_q.push_back(e);
        rx_valid = 1'b1; rx_id = id; rx_ext = ext;
    endtask

    // Driver: one-cycle strobe, result compared by the monitor
    task automatic frame(input logic [28:0] id, input logic ext,
                         input logic h, input logic [3:0] ix, input string tag);
        push_frame(id, ext, h, ix, tag);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset outputs", 1'b0, 4'd0);
        rst_n = 1'b1;
        @(negedge clk);

        frame(29'h123, 1'b0, 1'b0, 0, "R1 slots disabled after reset");

        wr(5'd3, 29'h123, 1'b0, 1'b1, 1'b0);
        frame(29'h123, 1'b0, 1'b1, 3, "R3 standard exact match");
        frame(29'h124, 1'b0, 1'b0, 0, "R4 all-ones mask demands equality");
        frame({18'h3FFFF, 11'h123}, 1'b0, 1'b1, 3, "R3 upper bits ignored for standard");
        frame(29'h123, 1'b1, 1'b0, 0, "R5 extended frame vs standard slot");

        wr(5'd5, 29'h1ABCDE0, 1'b0, 1'b1, 1'b1);
        frame(29'h1ABCDE0, 1'b1, 1'b1, 5, "R3 extended exact match");
        frame(29'h1ABCDE7, 1'b1, 1'b0, 0, "R3 extended low bits compared");

        wr(5'd0, 29'h1FFFFFF0, 1'b0, 1'b0, 1'b0);
        frame(29'h12F, 1'b0, 1'b1, 3, "R4 masked standard bits ignored");
        frame(29'h1ABCDE7, 1'b1, 1'b1, 5, "R4 masked extended bits ignored");

        wr(5'd2, 29'h120, 1'b0, 1'b1, 1'b0);
        frame(29'h125, 1'b0, 1'b1, 2, "R7 lowest slot wins");

        wr(5'd2, 29'h120, 1'b1, 1'b1, 1'b0);
        frame(29'h125, 1'b0, 1'b1, 3, "R6 transmit slot never hits");
        wr(5'd3, 29'h120, 1'b0, 1'b0, 1'b0);
        frame(29'h125, 1'b0, 1'b0, 0, "R6 disabled slot never hits");

        wr(5'd0, 29'h1FFFFFFF, 1'b0, 1'b0, 1'b0);
        wr(5'd16, 29'h1FFFFF00, 1'b0, 1'b0, 1'b0);
        wr(5'd15, 29'h340, 1'b1, 1'b1, 1'b0);
        frame(29'h3A7, 1'b0, 1'b1, 15, "R8 last slot own mask, direction discarded");
        frame(29'h3A7, 1'b1, 1'b0, 0, "R5 last slot format");

        wr(5'd7, 29'h3A7, 1'b0, 1'b1, 1'b0);
        frame(29'h3A7, 1'b0, 1'b1, 7, "R7 slot 7 beats slot 15");

        // Write and frame in the same cycle: frame judged on old contents
        set_cfg(5'd7, 29'h3A7, 1'b0, 1'b0, 1'b0);
        push_frame(29'h3A7, 1'b0, 1'b1, 7, "R9 same-cycle write not yet visible");
        @(negedge clk);
        cfg_we = 1'b0; rx_valid = 1'b0;
        frame(29'h3A7, 1'b0, 1'b1, 15, "R9 write visible on next frame");

        wr(5'd17, 29'h0, 1'b0, 1'b0, 1'b0);
        frame(29'h3A7, 1'b0, 1'b1, 15, "R9 address 17 changes nothing");

        // Back-to-back strobes
        push_frame(29'h3A7, 1'b0, 1'b1, 15, "R2 back-to-back first");
        @(negedge clk);
        push_frame(29'h124, 1'b0, 1'b0, 0, "R2 back-to-back miss");
        @(negedge clk);
        push_frame(29'h3A0, 1'b0, 1'b1, 15, "R2 back-to-back third");
        @(negedge clk);
        rx_valid = 1'b0;
        @(negedge clk);
        check("R2 output clears after idle cycle", 1'b0, 4'd0);
        repeat (2) @(negedge clk);

        if (sb_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL R2: %0d results missing, expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #40000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule